// File: doc/BRIEF.md
# Retimed Two-Delay Recursive Filter

The block is a fixed-point recursive filter that computes y(n) = a·y(n-2) + x(n) on 16-bit signed Q1.15 data with a Q1.15 coefficient. Its feedback cycle holds exactly two registers. One register sits at the multiplier output and the other at the adder output, so every register-to-register path crosses one operator only. The clock period is therefore set by the slower of the multiplier and the adder, not by their sum. The filter behaves exactly as the plain two-delay equation, with one cycle from an accepted sample to its output.

Because the loop has two delays, the same datapath can also serve as a 2-slow version of the first-order filter y(n) = a·y(n-1) + x(n). A mode input selects one of three uses. The first is the plain two-delay filter. The second runs two independent first-order channels interleaved on alternate samples, with a channel tag that travels with each sample. The third runs one first-order channel: after each accepted sample the block inserts a zero sample into the loop by itself, and it raises output-valid only for real samples.

The loop advances only on cycles that carry a sample or on an inserted zero slot. Sums wrap in two's complement.

Top module: `retimed_iir2`

## Requirements
- R1: With mode_i = 2'b00 (or 2'b11), each accepted sample (in_valid_i high) yields out_valid_o high on the next cycle, with out_y_o = x(n) + round(a·y(n-2)). Here n counts accepted samples only.
- R2: The product a·y is rounded to Q1.15 by adding 2^14 to the 32-bit product and taking bits [30:15]. The sum with x wraps in 16-bit two's complement, so (-1)·(-1) gives -32768.
- R3: While rst_n is low, out_valid_o, out_y_o and out_ch_o are 0. After reset the first two outputs equal the first two input samples.
- R4: With mode_i = 2'b01 and samples alternating in_ch_i = 0, 1, 0, 1, …, the outputs of each channel match an independent first-order filter y = x + round(a·y_prev) for that channel. out_ch_o repeats in_ch_i one cycle later.
- R5: With mode_i = 2'b10, an accepted sample is followed by an automatic zero slot on the next cycle. Outputs for samples match one first-order filter y = x + round(a·y_prev). In the zero-slot cycle that follows, out_valid_o is low and out_y_o is 0.
- R6: In mode_i = 2'b10, in_valid_i and in_x_i on the zero-slot cycle are ignored: later outputs are unchanged by them.
- R7: On a cycle with no accepted sample and no zero slot, out_valid_o goes low on the next cycle and out_y_o keeps its value.
- R8: out_ch_o is 0 whenever mode_i is not 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid_i | input | 1 | Sample present this cycle |
| in_x_i | input | 16 | Signed Q1.15 input sample |
| coef_i | input | 16 | Signed Q1.15 feedback coefficient a |
| mode_i | input | 2 | 00 two-delay filter, 01 two interleaved channels, 10 single zero-stuffed channel, 11 as 00 |
| in_ch_i | input | 1 | Channel tag of the input sample |
| out_valid_o | output | 1 | Output sample valid |
| out_y_o | output | 16 | Signed Q1.15 output sample |
| out_ch_o | output | 1 | Channel tag of the output sample |

## Verification
The bench builds the block with its default width of 16 bits, so Q1.15 is exact. At that width the rounding corners can be reached directly: the -1·-1 product wraps, a half-LSB product rounds upward, and a sum past +1 wraps. Coefficients of both signs and near full scale are used, so the two-delay, interleaved and zero-stuffed uses are each compared against behavioural first- and second-order references. The bench also inserts idle gaps and junk samples on zero slots.

// File: rtl/retimed_iir2_pkg.sv
package retimed_iir2_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_PAIR   = 2'b01,
    MODE_STUFF  = 2'b10,
    MODE_RSVD   = 2'b11
  } iir_mode_e;
endpackage

// File: rtl/retimed_iir2_mul.sv
// Multiplier stage: rounded product registered (the retimed loop delay).
module retimed_iir2_mul #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] coef,
  input  logic signed [W-1:0] y_in,
  output logic signed [W-1:0] m_q
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] RND_HALF = PW'(1) << (W - 2);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] biased;
  logic signed [W-1:0]  m_d;

  always_comb begin
    prod   = PW'(coef) * PW'(y_in);
    biased = prod + RND_HALF;
    m_d    = biased[PW-2:W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
    end else if (en) begin
      m_q <= m_d;
    end
  end
endmodule

// File: rtl/retimed_iir2_add.sv
// Adder stage: wrapping sum registered as the filter output.
module retimed_iir2_add #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] m_in,
  output logic signed [W-1:0] y_q
);
  logic signed [W-1:0] y_d;

  always_comb begin
    y_d = x_in + m_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (en) begin
      y_q <= y_d;
    end
  end
endmodule

// File: rtl/retimed_iir2_ctl.sv
// Slot control: loop advance, zero-slot insertion, output valid and tag.
module retimed_iir2_ctl
  import retimed_iir2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] mode,
  input  logic       in_ch,
  output logic       adv,
  output logic       zslot_q,
  output logic       out_valid_q,
  output logic       out_ch_q
);
  logic take;
  logic zslot_d;
  logic out_valid_d;
  logic out_ch_d;

  always_comb begin
    take        = in_valid && !zslot_q;
    adv         = take || zslot_q;
    zslot_d     = take && (mode == MODE_STUFF);
    out_valid_d = take;
    out_ch_d    = (take && (mode == MODE_PAIR)) ? in_ch : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zslot_q     <= 1'b0;
      out_valid_q <= 1'b0;
      out_ch_q    <= 1'b0;
    end else begin
      zslot_q     <= zslot_d;
      out_valid_q <= out_valid_d;
      out_ch_q    <= out_ch_d;
    end
  end
endmodule

// File: rtl/retimed_iir2.sv
module retimed_iir2 #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid_i,
  input  logic signed [W-1:0] in_x_i,
  input  logic signed [W-1:0] coef_i,
  input  logic [1:0]          mode_i,
  input  logic                in_ch_i,
  output logic                out_valid_o,
  output logic signed [W-1:0] out_y_o,
  output logic                out_ch_o
);
  logic                rst_meta;
  logic                rst_n_s;
  logic                adv;
  logic                zslot;
  logic signed [W-1:0] x_eff;
  logic signed [W-1:0] m_q;
  logic signed [W-1:0] y_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  retimed_iir2_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .in_valid    (in_valid_i),
    .mode        (mode_i),
    .in_ch       (in_ch_i),
    .adv         (adv),
    .zslot_q     (zslot),
    .out_valid_q (out_valid_o),
    .out_ch_q    (out_ch_o)
  );

  always_comb begin
    x_eff = zslot ? '0 : in_x_i;
  end

  retimed_iir2_add #(.W(W)) u_add (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (adv),
    .x_in  (x_eff),
    .m_in  (m_q),
    .y_q   (y_q)
  );

  retimed_iir2_mul #(.W(W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (adv),
    .coef  (coef_i),
    .y_in  (y_q),
    .m_q   (m_q)
  );

  assign out_y_o = y_q;
endmodule

// File: rtl/retimed_iir2_chk.sv
module retimed_iir2_chk
  import retimed_iir2_pkg::*;
#(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n_s,
  input logic                in_valid_i,
  input logic [1:0]          mode_i,
  input logic                in_ch_i,
  input logic                zslot,
  input logic                out_valid_o,
  input logic signed [W-1:0] out_y_o,
  input logic                out_ch_o
);
  AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid_i && !zslot && mode_i != MODE_STUFF) |=> out_valid_o); // R1
  AST_TAG_ECHO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid_i && !zslot && mode_i == MODE_PAIR) |=> (out_ch_o == $past(in_ch_i))); // R4
  AST_STUFF_SLOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid_i && !zslot && mode_i == MODE_STUFF) |=> zslot); // R5
  AST_ZERO_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    zslot |=> (!out_valid_o && !zslot)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!in_valid_i && !zslot) |=> (!out_valid_o && $stable(out_y_o))); // R7
  AST_TAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_i != MODE_PAIR) |=> !out_ch_o); // R8
endmodule

bind retimed_iir2 retimed_iir2_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .in_valid_i  (in_valid_i),
  .mode_i      (mode_i),
  .in_ch_i     (in_ch_i),
  .zslot       (zslot),
  .out_valid_o (out_valid_o),
  .out_y_o     (out_y_o),
  .out_ch_o    (out_ch_o)
);

// File: tb/retimed_iir2_tb_top.sv
module retimed_iir2_tb_top;
  localparam int W = 16;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic signed [W-1:0] in_x;
  logic signed [W-1:0] coef;
  logic [1:0]          mode;
  logic                in_ch;
  logic                out_valid;
  logic signed [W-1:0] out_y;
  logic                out_ch;

  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;
  int unsigned seed   = 32'h1234_5678;

  always #10 clk = ~clk;

  retimed_iir2 #(.W(W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .in_x_i      (in_x),
    .coef_i      (coef),
    .mode_i      (mode),
    .in_ch_i     (in_ch),
    .out_valid_o (out_valid),
    .out_y_o     (out_y),
    .out_ch_o    (out_ch)
  );

  function automatic int wrapw(int v);
    return (v <<< (32 - W)) >>> (32 - W);
  endfunction

  function automatic int rnd(int a, int y);
    int p;
    p = a * y;
    p = (p + (1 <<< (W - 2))) >>> (W - 1);
    return wrapw(p);
  endfunction

  function automatic int nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return wrapw(int'(seed >> 8));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(bit v, int x, bit ch, bit ev, int ey, bit ech, string tag);
    @(negedge clk);
    in_valid = v;
    in_x     = x[W-1:0];
    in_ch    = ch;
    @(posedge clk);
    #1;
    chk({tag, " valid"}, int'(out_valid), int'(ev));
    chk({tag, " y"}, int'(out_y), ey);
    chk({tag, " ch"}, int'(out_ch), int'(ech));
  endtask

  task automatic do_reset(logic [1:0] m, int a);
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_x     = '0;
    in_ch    = 1'b0;
    mode     = m;
    coef     = a[W-1:0];
    repeat (2) @(negedge clk);
    chk("R3 reset valid", int'(out_valid), 0);
    chk("R3 reset y", int'(out_y), 0);
    chk("R3 reset ch", int'(out_ch), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int a;
    int y1, y2, yn, x;
    int yc[2];
    rst_n = 1'b0; in_valid = 1'b0; in_x = '0; coef = '0; mode = 2'b00; in_ch = 1'b0;

    // R1 / R3 / R7: two-delay filter, with idle gaps
    for (int run = 0; run < 2; run++) begin
      a = (run == 0) ? 21000 : -27000;
      do_reset((run == 0) ? 2'b00 : 2'b11, a);
      y1 = 0; y2 = 0;
      for (int i = 0; i < 40; i++) begin
        if (i % 5 == 4) begin
          tick(1'b0, nxt(), 1'b0, 1'b0, y1, 1'b0, "R7 idle hold");
        end else begin
          x  = nxt();
          yn = wrapw(x + rnd(a, y2));
          if (i < 2) chk("R3 first outputs equal inputs", yn, x);
          tick(1'b1, x, 1'b1, 1'b1, yn, 1'b0, "R1 R8 two-delay");
          y2 = y1; y1 = yn;
        end
      end
    end

    // R2: rounding and wrap corners
    do_reset(2'b00, 1);
    tick(1'b1, 16384, 1'b0, 1'b1, 16384, 1'b0, "R2 seed");
    tick(1'b1, 16383, 1'b0, 1'b1, 16383, 1'b0, "R2 seed");
    tick(1'b1, 0, 1'b0, 1'b1, 1, 1'b0, "R2 half rounds up");
    tick(1'b1, 0, 1'b0, 1'b1, 0, 1'b0, "R2 below half rounds down");
    do_reset(2'b00, -32768);
    tick(1'b1, -32768, 1'b0, 1'b1, -32768, 1'b0, "R2 seed");
    tick(1'b1, 0, 1'b0, 1'b1, 0, 1'b0, "R2 seed");
    tick(1'b1, 0, 1'b0, 1'b1, -32768, 1'b0, "R2 minus one squared wraps");
    do_reset(2'b00, 16384);
    tick(1'b1, 32767, 1'b0, 1'b1, 32767, 1'b0, "R2 seed");
    tick(1'b1, 0, 1'b0, 1'b1, 0, 1'b0, "R2 seed");
    tick(1'b1, 32767, 1'b0, 1'b1, -16385, 1'b0, "R2 sum wraps");

    // R4: two interleaved first-order channels
    a = -12000;
    do_reset(2'b01, a);
    yc[0] = 0; yc[1] = 0;
    for (int i = 0; i < 32; i++) begin
      int c;
      c = i % 2;
      x = nxt();
      yc[c] = wrapw(x + rnd(a, yc[c]));
      tick(1'b1, x, c[0], 1'b1, yc[c], c[0], "R4 interleaved");
      if (i % 7 == 6) tick(1'b0, 0, 1'b0, 1'b0, yc[c], 1'b0, "R7 interleaved gap");
    end

    // R5 / R6 / R8: single zero-stuffed channel with junk on zero slots
    a = 30000;
    do_reset(2'b10, a);
    yn = 0;
    for (int i = 0; i < 16; i++) begin
      x  = nxt();
      yn = wrapw(x + rnd(a, yn));
      tick(1'b1, x, 1'b1, 1'b1, yn, 1'b0, "R5 R8 stuffed sample");
      tick(i % 2 == 0, nxt(), 1'b1, 1'b0, 0, 1'b0, "R6 zero slot");
      if (i % 4 == 3) tick(1'b0, 0, 1'b0, 1'b0, 0, 1'b0, "R7 stuffed idle");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule